// File: doc/BRIEF.md
# Programmable Refresh Interval Timer

This block paces periodic refresh work for a memory controller. A wide up-counter runs freely from reset. When it has run for the number of cycles held in a programmable limit register, the block raises a refresh request for a single clock and starts the next interval from zero. A host CPU sets the interval through a plain write port made of a strobe and a data word. The interval can be changed at any time without risk.

The hazard with such a timer is a limit written below the value the counter has already reached. If the match test were pure equality, the counter would have to run through its whole range before matching again, and refreshes would be lost. Here any write clears the count and raises a refresh request at once. The compare is also a greater-than-or-equal test, so no match can be stepped over. A limit of zero is taken as one, which gives a request on every cycle.

The controller answers each request on an acknowledge input. If a new request is issued while the previous one is still unanswered, a saturating overrun counter counts the event, and the count is driven out as a port.

Top module: `refresh_interval_timer`

## Requirements
- R1: While reset is high and on the first clock after it, `rfsh_req` is 0 and `overrun_count` is 0. The limit resets to DEFAULT_LIMIT, and the first request appears after exactly DEFAULT_LIMIT rising edges with reset low.
- R2: A clock edge with `lim_wr_en` high clears the count and makes `rfsh_req` 1 right after that edge, whatever the count was. The next periodic request follows after exactly the new limit in edges.
- R3: With a limit L of 2 or more and no write in between, consecutive requests are exactly L rising edges apart.
- R4: With a limit of 2 or more, `rfsh_req` is high for exactly one cycle per request.
- R5: Writing 0 to the limit acts as a limit of 1, so `rfsh_req` stays 1 on every cycle.
- R6: A request is outstanding from its issue until an edge where `rfsh_ack` is high. `overrun_count` rises by 1 on an edge that issues a new request while one is outstanding and `rfsh_ack` is low.
- R7: An acknowledge on the same edge as a new issue retires the old request, and no overrun is counted. With limit 1 and every request acknowledged one cycle later, `overrun_count` stays 0.
- R8: `overrun_count` saturates at 2^OVR_W-1 and never wraps or decreases outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_data | input | CNT_W | New interval in cycles (0 acts as 1) |
| rfsh_ack | input | 1 | Controller acknowledges the outstanding request |
| rfsh_req | output | 1 | Registered refresh request pulse |
| overrun_count | output | OVR_W | Saturating count of requests issued while one was outstanding |

## Verification
The bench builds the timer with a 16-bit counter, a default limit of 40 and a 3-bit overrun counter. The first post-reset request therefore arrives after 40 edges instead of 1024. Overrun saturation at 7 can be reached in a few dozen cycles of unanswered requests. Mid-interval writes, the zero-limit case and same-edge acknowledge against back-to-back issues all fit in a short run.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int RIT_CNT_W_DEF   = 32;
  localparam int RIT_OVR_W_DEF   = 8;
  localparam int RIT_LIMIT_DEF   = 1024;
endpackage

// File: rtl/rit_limit_reg.sv
module rit_limit_reg #(
  parameter int CNT_W         = rit_pkg::RIT_CNT_W_DEF,
  parameter int DEFAULT_LIMIT = rit_pkg::RIT_LIMIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] limit_q
);
  localparam logic [CNT_W-1:0] RST_LIM =
    (DEFAULT_LIMIT == 0) ? CNT_W'(1) : CNT_W'(DEFAULT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst)
      limit_q <= RST_LIM;
    else if (wr_en)
      limit_q <= (wr_data == '0) ? CNT_W'(1) : wr_data;
  end

  // R5: a zero write lands as a limit of one
  a_r5_zero_clamped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == '0) |=> (limit_q == CNT_W'(1)));
endmodule

// File: rtl/rit_interval_cnt.sv
module rit_interval_cnt #(
  parameter int CNT_W = rit_pkg::RIT_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             due,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] last_val;

  assign last_val = limit - CNT_W'(1);
  assign due      = (count_q >= last_val);

  always_ff @(posedge clk) begin
    if (rst || restart || due)
      count_q <= '0;
    else
      count_q <= count_q + CNT_W'(1);
  end

  // R3: the count never reaches the limit held by the limit register
  a_r3_count_below_limit: assert property (@(posedge clk) disable iff (rst)
    count_q < limit);
endmodule

// File: rtl/rit_overrun_mon.sv
module rit_overrun_mon #(
  parameter int OVR_W = rit_pkg::RIT_OVR_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             ack,
  output logic [OVR_W-1:0] ovr_q
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ovr_q  <= '0;
    end else begin
      if (issue) begin
        pend_q <= 1'b1;
        if (pend_q && !ack && ovr_q != OVR_MAX)
          ovr_q <= ovr_q + OVR_W'(1);
      end else if (ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R8: a saturated counter stays saturated
  a_r8_holds_at_max: assert property (@(posedge clk) disable iff (rst)
    (ovr_q == OVR_MAX) |=> (ovr_q == OVR_MAX));
  // R8: never decreases outside reset
  a_r8_no_decrease: assert property (@(posedge clk) disable iff (rst)
    (ovr_q != '0) |=> (ovr_q >= $past(ovr_q)));
  // R6: without a new issue the count does not move
  a_r6_only_on_issue: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(ovr_q));
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W         = rit_pkg::RIT_CNT_W_DEF,
  parameter int DEFAULT_LIMIT = rit_pkg::RIT_LIMIT_DEF,
  parameter int OVR_W         = rit_pkg::RIT_OVR_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lim_wr_en,
  input  logic [CNT_W-1:0] lim_wr_data,
  input  logic             rfsh_ack,
  output logic             rfsh_req,
  output logic [OVR_W-1:0] overrun_count
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_q;
  logic             due;
  logic             fire;

  assign fire = lim_wr_en | due;

  rit_limit_reg #(.CNT_W(CNT_W), .DEFAULT_LIMIT(DEFAULT_LIMIT)) u_limit (
    .clk(clk), .rst(rst), .wr_en(lim_wr_en), .wr_data(lim_wr_data),
    .limit_q(limit_q)
  );

  rit_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(lim_wr_en), .limit(limit_q),
    .due(due), .count_q(count_q)
  );

  rit_overrun_mon #(.OVR_W(OVR_W)) u_ovr (
    .clk(clk), .rst(rst), .issue(fire), .ack(rfsh_ack),
    .ovr_q(overrun_count)
  );

  always_ff @(posedge clk) begin
    if (rst) rfsh_req <= 1'b0;
    else     rfsh_req <= fire;
  end

  // R2: a limit write is followed by a request
  a_r2_write_forces_req: assert property (@(posedge clk) disable iff (rst)
    lim_wr_en |=> rfsh_req);
  // R2: a request always starts a fresh interval
  a_r2_req_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
    rfsh_req |-> (count_q == '0));
  // R4: with limit two or more and no write, no back-to-back requests
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && limit_q > CNT_W'(1) && !lim_wr_en) |=> !rfsh_req);
endmodule

// File: tb/sim_refresh_interval_timer.sv
module sim_refresh_interval_timer;
  localparam int CNT_W = 16;
  localparam int DEFL  = 40;
  localparam int OVR_W = 3;
  localparam int OMAX  = (1 << OVR_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr  = 1'b0;
  logic [CNT_W-1:0] wdata = '0;
  logic             ack = 1'b0;
  logic             req;
  logic [OVR_W-1:0] ovr;

  refresh_interval_timer #(.CNT_W(CNT_W), .DEFAULT_LIMIT(DEFL), .OVR_W(OVR_W)) u0 (
    .clk(clk), .rst(rst), .lim_wr_en(wr), .lim_wr_data(wdata),
    .rfsh_ack(ack), .rfsh_req(req), .overrun_count(ovr)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    cmp_on = 1'b0;
  bit    auto_ack = 1'b0;
  string tag = "R1";

  // behavioural reference
  longint m_cnt = 0, m_lim = DEFL;
  int     m_ovr = 0;
  bit     m_pend = 0, m_req = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lim = DEFL; m_ovr = 0; m_pend = 0; m_req = 0;
    end else begin
      bit f;
      f = wr || (m_cnt >= m_lim - 1);
      if (f) begin
        if (m_pend && !ack && m_ovr < OMAX) m_ovr++;
        m_pend = 1;
      end else if (ack) m_pend = 0;
      m_cnt = f ? 0 : m_cnt + 1;
      if (wr) m_lim = (wdata == 0) ? 1 : wdata;
      m_req = f;
    end
  end

  task automatic chk(input string t, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({tag, " req"}, int'(req), int'(m_req));
      chk({tag, " overrun"}, int'(ovr), m_ovr);
    end
    ack <= auto_ack && req;
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_lim(input int v);
    wr = 1'b1; wdata = CNT_W'(v);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic gap_to_req(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!req && k < 5000);
  endtask

  initial begin
    int g;
    // R1 reset state and first default interval
    auto_ack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 req in reset", int'(req), 0);
    chk("R1 overrun in reset", int'(ovr), 0);
    do_reset();
    cmp_on = 1'b1;
    gap_to_req(g);
    chk("R1 first interval", g, DEFL);
    // R4 single pulse
    @(negedge clk);
    chk("R4 pulse low next cycle", int'(req), 0);
    // R2 write mid-interval below current count
    tag = "R2";
    repeat (20) @(negedge clk);
    write_lim(7);
    chk("R2 forced request", int'(req), 1);
    gap_to_req(g);
    chk("R2 next after write", g, 7);
    // R3 steady period
    tag = "R3";
    gap_to_req(g);
    chk("R3 period 7", g, 7);
    write_lim(23);
    gap_to_req(g);
    chk("R3 period 23", g, 23);
    gap_to_req(g);
    chk("R3 period 23 again", g, 23);
    tag = "R4";
    write_lim(2);
    for (int i = 0; i < 10; i++) @(negedge clk);
    // R5 zero limit
    tag = "R5";
    write_lim(0);
    for (int i = 0; i < 6; i++) begin
      chk("R5 request every cycle", int'(req), 1);
      @(negedge clk);
    end
    // R7 same-edge ack on limit 1
    tag = "R7";
    repeat (20) @(negedge clk);
    chk("R7 no overrun with same-edge ack", int'(ovr), 0);
    // R6 unanswered requests
    tag = "R6";
    auto_ack = 1'b0;
    @(negedge clk);
    do_reset();
    write_lim(5);
    chk("R6 write request", int'(req), 1);
    repeat (5) @(negedge clk);
    chk("R6 second issue", int'(req), 1);
    chk("R6 one overrun", int'(ovr), 1);
    // R8 saturation
    tag = "R8";
    repeat (60) @(negedge clk);
    chk("R8 saturated", int'(ovr), OMAX);
    repeat (20) @(negedge clk);
    chk("R8 still saturated", int'(ovr), OMAX);
    auto_ack = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 holds after acks", int'(ovr), OMAX);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule